// File: doc/BRIEF.md
# Multiprocessor-Addressed Serial Receiver

This block receives asynchronous serial frames on a single input line and holds each accepted byte in a receive data register that software reads through a small register port. Every frame carries one extra address-flag bit after the eight data bits. The flag is 1 for a station-address frame and 0 for a payload frame. Several stations can share one line this way, and each station only takes in traffic meant for it.

Software arms an address hunt by setting a hunt bit in the control register. While the hunt bit is set, the receiver discards payload frames without any trace. The first address frame is loaded into the data register, raises the ready flag and clears the hunt bit in hardware. Software then compares the byte with its own station number. On a mismatch it re-arms the hunt and clears the ready flag. On a match it leaves the hunt bit clear and reads the payload frames that follow.

An overrun flag and a framing-error flag are sticky. While either one is set, the receiver ignores the line until software writes them clear. The live, synchronised line level can be read as a status bit, so that a break (line held low) can be seen after a framing error.

Top module: `mpr_uart_rx`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, and the status register reads 0x10 (all flags clear, line bit high with the line idle).
- R2: A frame is a low start bit, 8 data bits least significant first, one address-flag bit, then a high stop bit, each lasting OVERSAMPLE*TICK_DIV clocks. A completed frame loads the byte into the data register, copies the flag into status bit 3 and sets ready (status bit 0).
- R3: While the hunt bit (control bit 1) is 1, a frame whose flag bit is 0 changes none of: data register, ready, overrun, framing error.
- R4: While the hunt bit is 1, a frame whose flag bit is 1 is handled like a normal frame and clears the hunt bit.
- R5: A frame that completes while ready is 1 sets overrun (status bit 1) and leaves the data register and the flag bit unchanged.
- R6: A stop bit sampled low sets framing error (status bit 2). The byte is still loaded when ready was 0.
- R7: While overrun or framing error is 1, complete frames on the line have no effect. Once both are cleared, reception resumes.
- R8: While receive enable (control bit 0) is 0, frames have no effect.
- R9: Status bit 4 follows the serial input level, delayed by the two-stage input synchroniser.
- R10: A low pulse shorter than half a bit time is rejected as a false start and loads nothing.
- R11: Register map: address 0 is control, address 1 is status, address 2 is data (read-only), and address 3 reads 0. A write to status clears each of bits 0 to 2 where the written bit is 0 and leaves it unchanged where the written bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial input line |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |

## Verification
The bench drives payload frames while the hunt bit is armed. A receiver that loaded these frames, or let them raise overrun or framing error, would show a changed data or status register. It sends an address frame and checks that the hunt bit has dropped, since a design that forgot to clear it would keep skipping the payload that follows. It sends back-to-back frames without a clear, which catches designs that overwrite the held byte on overrun. It sends frames while a sticky flag is set, which catches designs that keep receiving. It also covers a bad stop bit followed by a held-low break, a sub-half-bit glitch that a careless start detector would accept as a frame, and write-one-has-no-effect on the status flags. Randomised frame, flag and clear sequences are compared against a bench model of the whole register state.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 2;   // data + address flag + stop

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS
    } mpr_rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mp;
        logic              stop_ok;
    } mpr_frame_t;

    typedef struct packed {
        logic id_wait;
        logic rx_en;
    } mpr_ctrl_t;

    typedef struct packed {
        mpr_ctrl_t         ctrl;
        logic              ready;
        logic              ovr;
        logic              fer;
        logic              mp;
        logic [DATA_W-1:0] data;
    } mpr_regs_t;

    // shift register holds bits in arrival order, first bit at index 0
    function automatic mpr_frame_t mpr_unpack(input logic [FRAME_W-1:0] sh);
        mpr_frame_t f;
        f.data    = sh[DATA_W-1:0];
        f.mp      = sh[DATA_W];
        f.stop_ok = sh[DATA_W+1];
        return f;
    endfunction

endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpr_tick_gen.sv
module mpr_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV > 1) begin : g_div
            logic [TW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)                          cnt <= '0;
                else if (cnt == TW'(TICK_DIV-1))  cnt <= '0;
                else                              cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == TW'(TICK_DIV-1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/mpr_rx_framer.sv
module mpr_rx_framer
    import mpr_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic       rx,
    output logic       frame_done,
    output mpr_frame_t frame
);
    localparam int CW   = $clog2(OVERSAMPLE);
    localparam int IW   = $clog2(FRAME_W);
    localparam int HALF = OVERSAMPLE / 2;

    mpr_rx_state_e      state;
    logic [CW-1:0]      cnt;
    logic [IW-1:0]      idx;
    logic [FRAME_W-1:0] shreg;
    logic               done_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            idx    <= '0;
            done_q <= 1'b0;
            if (rst) shreg <= '0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        if (!rx) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CW'(HALF-1)) begin
                            cnt <= '0;
                            idx <= '0;
                            state <= rx ? RX_IDLE : RX_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_BITS: begin
                        if (cnt == CW'(OVERSAMPLE-1)) begin
                            cnt   <= '0;
                            shreg <= {rx, shreg[FRAME_W-1:1]};
                            if (idx == IW'(FRAME_W-1)) begin
                                done_q <= 1'b1;
                                state  <= RX_IDLE;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign frame_done = done_q;
    assign frame      = mpr_unpack(shreg);
endmodule

// File: rtl/mpr_regs.sv
module mpr_regs
    import mpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  mpr_frame_t        frame,
    input  logic              line,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output mpr_regs_t         regs,
    output logic              run
);
    mpr_regs_t q, n;
    logic accept, load, ctrl_wr, stat_wr;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[DATA_W-1:3];

    always_comb begin
        accept  = frame_done && !(q.ctrl.id_wait && !frame.mp);
        load    = accept && !q.ready;
        ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
        stat_wr = reg_wr && (reg_addr == ADDR_STAT);

        n = q;
        if (load) begin
            n.data = frame.data;
            n.mp   = frame.mp;
        end
        if (accept && q.ctrl.id_wait) n.ctrl.id_wait = 1'b0;
        if (ctrl_wr) begin
            n.ctrl.rx_en   = reg_wdata[0];
            n.ctrl.id_wait = reg_wdata[1];
        end
        // hardware set wins over a software clear in the same cycle
        n.ready = (stat_wr ? (q.ready & reg_wdata[0]) : q.ready) | load;
        n.ovr   = (stat_wr ? (q.ovr   & reg_wdata[1]) : q.ovr)   | (accept && q.ready);
        n.fer   = (stat_wr ? (q.fer   & reg_wdata[2]) : q.fer)   | (accept && !frame.stop_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {6'b0, q.ctrl.id_wait, q.ctrl.rx_en};
            ADDR_STAT: reg_rdata = {3'b0, line, q.mp, q.fer, q.ovr, q.ready};
            ADDR_DATA: reg_rdata = q.data;
            default:   reg_rdata = '0;
        endcase
    end

    assign regs = q;
    assign run  = q.ctrl.rx_en && !q.ovr && !q.fer;
endmodule

// File: rtl/mpr_uart_rx.sv
module mpr_uart_rx
    import mpr_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int TICK_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    logic       rx_s;
    logic       tick;
    logic       run;
    logic       frame_done;
    mpr_frame_t rx_frame;
    mpr_regs_t  regs_q;

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .din (rxd), .dout (rx_s)
    );

    mpr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk (clk), .rst (rst), .tick (tick)
    );

    mpr_rx_framer #(.OVERSAMPLE(OVERSAMPLE)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .tick       (tick),
        .rx         (rx_s),
        .frame_done (frame_done),
        .frame      (rx_frame)
    );

    mpr_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .frame      (rx_frame),
        .line       (rx_s),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .regs       (regs_q),
        .run        (run)
    );
endmodule

// File: rtl/mpr_uart_rx_chk.sv
module mpr_uart_rx_chk
    import mpr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              frame_done,
    input logic              frame_mp,
    input logic              rx_en,
    input logic              id_wait,
    input logic              ready,
    input logic              ovr,
    input logic              fer,
    input logic [DATA_W-1:0] data_q
);
    a_r2_ready_from_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(frame_done));

    a_r3_drop_payload: assert property (@(posedge clk) disable iff (rst)
        (frame_done && id_wait && !frame_mp && !reg_wr)
        |=> ($stable(data_q) && $stable(ready) && $stable(ovr) && $stable(fer)));

    a_r4_hunt_cleared: assert property (@(posedge clk) disable iff (rst)
        (frame_done && id_wait && frame_mp && !reg_wr) |=> !id_wait);

    a_r5_overrun_holds_data: assert property (@(posedge clk) disable iff (rst)
        (frame_done && ready && !(id_wait && !frame_mp) && !reg_wr)
        |=> (ovr && $stable(data_q)));

    a_r7_frozen_on_error: assert property (@(posedge clk) disable iff (rst)
        (ovr || fer) |=> !frame_done);

    a_r8_disabled_no_frame: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !frame_done);
endmodule

bind mpr_uart_rx mpr_uart_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .frame_done (frame_done),
    .frame_mp   (rx_frame.mp),
    .rx_en      (regs_q.ctrl.rx_en),
    .id_wait    (regs_q.ctrl.id_wait),
    .ready      (regs_q.ready),
    .ovr        (regs_q.ovr),
    .fer        (regs_q.fer),
    .data_q     (regs_q.data)
);

// File: tb/sim_mpr_uart_rx.sv
`timescale 1ns/1ps
module sim_mpr_uart_rx;
    localparam int OVS  = 16;
    localparam int TDIV = 4;
    localparam int BIT  = OVS * TDIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model of the register state
    bit       m_rxen, m_idw, m_ready, m_ovr, m_fer, m_mp;
    bit [7:0] m_data;

    always #2.5 clk = ~clk;

    mpr_uart_rx #(.OVERSAMPLE(OVS), .TICK_DIV(TDIV)) u0 (
        .clk (clk), .rst (rst), .rxd (rxd),
        .reg_addr (reg_addr), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
    );

    function automatic bit [7:0] exp_ctrl();
        return {6'b0, m_idw, m_rxen};
    endfunction

    function automatic bit [7:0] exp_stat(input bit line);
        return {3'b0, line, m_mp, m_fer, m_ovr, m_ready};
    endfunction

    function automatic void model_frame(input bit [7:0] b, input bit mp, input bit stop);
        if (!m_rxen || m_ovr || m_fer) return;
        if (m_idw && !mp) return;
        if (m_idw) m_idw = 1'b0;
        if (!stop) m_fer = 1'b1;
        if (m_ready) m_ovr = 1'b1;
        else begin m_data = b; m_mp = mp; m_ready = 1'b1; end
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr_ctrl(input bit en, input bit idw);
        reg_write(2'd0, {6'b0, idw, en});
        m_rxen = en; m_idw = idw;
    endtask

    task automatic clr_flags();
        reg_write(2'd1, 8'h00);
        m_ready = 0; m_ovr = 0; m_fer = 0;
    endtask

    task automatic send(input bit [7:0] b, input bit mp, input bit stop, input bit hold_low);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = mp;
        repeat (BIT) @(negedge clk);
        rxd = stop;
        repeat (BIT) @(negedge clk);
        rxd = hold_low ? 1'b0 : 1'b1;
        repeat (BIT) @(negedge clk);
        model_frame(b, mp, stop);
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        reg_read(2'd0, v); check({tag, " ctrl"}, v, exp_ctrl());
        reg_read(2'd1, v); check({tag, " stat"}, v, exp_stat(rxd));
        reg_read(2'd2, v); check({tag, " data"}, v, m_data);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h1357));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state, R11 unused address
        check_all("R1 reset");
        reg_read(2'd3, v); check("R11 addr3", v, 8'h00);

        // R8 disabled receiver ignores frames
        send(8'h5A, 1'b0, 1'b1, 1'b0);
        check_all("R8 disabled");

        // R2 plain frame
        wr_ctrl(1'b1, 1'b0);
        send(8'hA5, 1'b0, 1'b1, 1'b0);
        check_all("R2 frame");

        // R5 overrun keeps data, then R7 frozen
        send(8'h3C, 1'b1, 1'b1, 1'b0);
        check_all("R5 overrun");
        send(8'h77, 1'b0, 1'b1, 1'b0);
        check_all("R7 frozen ovr");

        // R11 writing ones leaves flags, zeros clear
        reg_write(2'd1, 8'hFF);
        check_all("R11 write ones");
        clr_flags();
        check_all("R11 clear");
        send(8'hC3, 1'b1, 1'b1, 1'b0);
        check_all("R7 resumed");
        clr_flags();

        // R3 hunt drops payload, R4 address frame loads and clears hunt
        wr_ctrl(1'b1, 1'b1);
        send(8'h11, 1'b0, 1'b0, 1'b0);
        check_all("R3 drop payload");
        send(8'h42, 1'b1, 1'b1, 1'b0);
        check_all("R4 id frame");
        send(8'h99, 1'b0, 1'b1, 1'b0);
        check_all("R4 after hunt ovr");
        clr_flags();

        // R6 framing error still loads byte
        send(8'h6E, 1'b0, 1'b0, 1'b0);
        check_all("R6 framing");
        send(8'h12, 1'b0, 1'b1, 1'b0);
        check_all("R7 frozen fer");
        clr_flags();

        // R9 break: line held low after bad stop
        send(8'h00, 1'b0, 1'b0, 1'b1);
        reg_read(2'd1, v); check("R9 break low", v, exp_stat(1'b0));
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        reg_read(2'd1, v); check("R9 line high", v, exp_stat(1'b1));
        clr_flags();

        // R10 short glitch rejected
        @(negedge clk); rxd = 1'b0;
        repeat (2 * TDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        check_all("R10 glitch");

        // randomised traffic against the model (R2 R3 R4 R5 R6 R7)
        for (int k = 0; k < 40; k++) begin
            bit [7:0] b;
            bit mp, stop;
            if ($urandom % 4 == 0) wr_ctrl(1'b1, 1'b1);
            if ($urandom % 2 == 0) clr_flags();
            b    = 8'($urandom);
            mp   = 1'($urandom);
            stop = m_idw ? 1'b1 : ($urandom % 8 != 0);
            send(b, mp, stop, 1'b0);
            check_all($sformatf("R2 random %0d", k));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule